// File: doc/BRIEF.md
# Parallel Video Line Scrambler with NRZI Encoder

This block is the transmit-side channel coder of a high-definition serial digital video link. On every word clock it accepts one 20-bit parallel word and hands one 20-bit coded word to an external serializer. The upper ten bits of the word carry a luma sample and the lower ten bits carry an interleaved chroma sample.

The coding is a self-synchronizing scrambler with generator x^9 + x^4 + 1, followed by an NRZI stage with generator x + 1. The word is taken as twenty consecutive serial bit times, bit 0 first. Both recurrences are unrolled across the word, so the parallel output is bit-for-bit what a serial scrambler and NRZI encoder would emit for the same least-significant-bit-first stream. The last nine scrambled bits and the last NRZI output bit are kept as state from one word to the next.

Top module: `hd_tx_coder`

## Requirements
- R1: For serial bit index n, the scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9]. The history runs continuously across word boundaries.
- R2: The coded bit is y[n] = s[n] XOR y[n-1], so a 1 in the scrambled stream toggles the line and a 0 holds it.
- R3: Bit 0 of a word is serial bit time 0 and bit 19 is serial bit time 19, both at the input and at the output. The luma sample occupies bits [19:10] and the chroma sample bits [9:0].
- R4: A word presented before a rising clock edge appears coded at the output right after that edge. The output does not change between edges.
- R5: When rst_n is 0 at a rising edge, the output becomes all zeros and the scrambler history and the NRZI line level clear to zero. Coding after reset restarts from that all-zero state.
- R6: The output for a word depends on the words before it through the nine-bit scrambler history and the NRZI line level. The same input word applied twice in a row generally codes differently.
- R7: From the cleared state, all-zero input words produce all-zero output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, rising edge active (nominally 74.25 MHz) |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 20 | Parallel word; [19:10] luma, [9:0] chroma; bit 0 sent first |
| out_word | output | 20 | Scrambled, NRZI-coded word for the serializer; bit 0 sent first |

## Verification
All-zero input after reset shows that the cleared state is a fixed point. Single-bit impulses at bit 0 and at bit 19 show whether the serial order runs from the least significant bit and whether the taps fall at the right distances. Runs of all-ones words and repeated identical words separate the NRZI toggling and the carried history from a coder that restarts every word. Long random streams, with resets in the middle, are compared every clock against a serial bit-by-bit model. This catches errors in tap placement, in the state carried across words and in the recovery from reset.

// File: rtl/hdtx_pkg.sv
// Shared sizing for the transmit channel coder.
// Assumes the word is at least one bit longer than the scrambler history.
package hdtx_pkg;
    localparam int WORD_W  = 20; // serial bit times per word clock
    localparam int SCR_LEN = 9;  // highest power of the scrambler generator
    localparam int SCR_TAP = 4;  // middle power of the scrambler generator
endpackage

// File: rtl/hdtx_scrambler_unroll.sv
// Combinational unroll of the x^SCR_LEN + x^SCR_TAP + 1 self-synchronizing
// scrambler over WORD_W serial bit times, bit 0 first.
// Assumes hist_in[SCR_LEN-1] is the most recent scrambled bit of the previous
// word and hist_in[0] the oldest. hist_out uses the same ordering.
module hdtx_scrambler_unroll #(
    parameter int WORD_W  = 20,
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 4
) (
    input  logic [SCR_LEN-1:0] hist_in,
    input  logic [WORD_W-1:0]  data_in,
    output logic [WORD_W-1:0]  scr_out,
    output logic [SCR_LEN-1:0] hist_out
);
    localparam int EXT_W = SCR_LEN + WORD_W;

    logic [EXT_W-1:0] ext;

    // Extend the history with each new scrambled bit in serial order.
    always_comb begin
        ext = '0;
        ext[SCR_LEN-1:0] = hist_in;
        for (int j = 0; j < WORD_W; j++) begin
            ext[SCR_LEN + j] = data_in[j] ^ ext[SCR_LEN + j - SCR_TAP] ^ ext[j];
        end
    end

    assign scr_out  = ext[EXT_W-1 -: WORD_W];
    assign hist_out = ext[EXT_W-1 -: SCR_LEN];
endmodule

// File: rtl/hdtx_nrzi_unroll.sv
// Combinational unroll of NRZI (x + 1) coding over WORD_W bit times.
// Assumes line_in is the last coded bit of the previous word.
module hdtx_nrzi_unroll #(
    parameter int WORD_W = 20
) (
    input  logic              line_in,
    input  logic [WORD_W-1:0] scr_in,
    output logic [WORD_W-1:0] code_out
);
    logic [WORD_W:0] level;

    assign level[0] = line_in;

    // Each scrambled 1 toggles the line level; bit j uses the level after bit j-1.
    for (genvar j = 0; j < WORD_W; j++) begin : g_lvl
        assign level[j+1] = level[j] ^ scr_in[j];
    end

    assign code_out = level[WORD_W:1];
endmodule

// File: rtl/hdtx_state_reg.sv
// State and output registers of the transmit coder.
// Assumes a synchronous active-low reset that clears every register to zero.
module hdtx_state_reg #(
    parameter int WORD_W  = 20,
    parameter int SCR_LEN = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  code_nxt,
    input  logic [SCR_LEN-1:0] hist_nxt,
    output logic [WORD_W-1:0]  code_q,
    output logic [SCR_LEN-1:0] hist_q,
    output logic               line_q
);
    // Capture the coded word, scrambler history and line level each word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            hist_q <= '0;
            line_q <= 1'b0;
        end else begin
            code_q <= code_nxt;
            hist_q <= hist_nxt;
            line_q <= code_nxt[WORD_W-1];
        end
    end
endmodule

// File: rtl/hd_tx_coder.sv
// Transmit channel coder: x^9+x^4+1 scrambler followed by NRZI, 20 bit times
// per clock, one clock of latency. Bit 0 is the first serialized bit.
// Assumes a synchronous active-low reset and a single rising-edge word clock.
module hd_tx_coder
    import hdtx_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int L = SCR_LEN,
    parameter int T = SCR_TAP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] out_word
);
    logic [L-1:0] scr_hist;
    logic [L-1:0] hist_nxt;
    logic         nrzi_last;
    logic [W-1:0] scr_word;
    logic [W-1:0] code_nxt;

    hdtx_scrambler_unroll #(.WORD_W(W), .SCR_LEN(L), .SCR_TAP(T)) i_scr (
        .hist_in (scr_hist),
        .data_in (in_word),
        .scr_out (scr_word),
        .hist_out(hist_nxt)
    );

    hdtx_nrzi_unroll #(.WORD_W(W)) i_nrzi (
        .line_in (nrzi_last),
        .scr_in  (scr_word),
        .code_out(code_nxt)
    );

    hdtx_state_reg #(.WORD_W(W), .SCR_LEN(L)) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_nxt(code_nxt),
        .hist_nxt(hist_nxt),
        .code_q  (out_word),
        .hist_q  (scr_hist),
        .line_q  (nrzi_last)
    );
endmodule

// File: rtl/hd_tx_coder_chk.sv
// Property checker for hd_tx_coder, attached by bind below.
// Assumes the scrambler history is ordered oldest bit first.
module hd_tx_coder_chk #(
    parameter int W = 20,
    parameter int L = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] in_word,
    input logic [W-1:0] out_word,
    input logic [L-1:0] scr_hist,
    input logic         nrzi_last
);
    // R5: reset clears the output and all coder state.
    a_r5_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_word == '0 && scr_hist == '0 && !nrzi_last));

    // R2: the carried line level is the last coded bit of the output word.
    a_r2_line_level: assert property (@(posedge clk) disable iff (!rst_n)
        nrzi_last == out_word[W-1]);

    // R6: the carried history equals the scrambled bits recovered from the output by undoing NRZI.
    a_r6_history_matches: assert property (@(posedge clk) disable iff (!rst_n)
        scr_hist == (out_word[W-1 -: L] ^ out_word[W-2 -: L]));

    // R7: the cleared state with zero input stays at zero.
    a_r7_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_hist == '0 && !nrzi_last && in_word == '0) |=> out_word == '0);
endmodule

bind hd_tx_coder hd_tx_coder_chk #(.W(W), .L(L)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_word  (in_word),
    .out_word (out_word),
    .scr_hist (scr_hist),
    .nrzi_last(nrzi_last)
);

// File: tb/test_hd_tx_coder.sv
`timescale 1ns/1ps
module test_hd_tx_coder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] in_word = '0;
    logic [19:0] out_word;

    int n_vec = 0;
    int n_bad = 0;

    bit sq[$];          // serial scrambled-bit history, newest at the back
    bit line_lvl;       // serial NRZI line level
    logic [19:0] exp_word = '0;

    always #2.5 clk = ~clk;

    hd_tx_coder i_hd_tx_coder (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_word (in_word),
        .out_word(out_word)
    );

    task automatic model_clear();
        sq.delete();
        for (int k = 0; k < 9; k++) sq.push_back(1'b0);
        line_lvl = 1'b0;
    endtask

    // Serial reference: feeds the word bit 0 first through scrambler then NRZI.
    function automatic logic [19:0] model_word(input logic [19:0] d);
        logic [19:0] r;
        for (int j = 0; j < 20; j++) begin
            bit s;
            s = d[j] ^ sq[sq.size()-4] ^ sq[sq.size()-9];
            sq.push_back(s);
            void'(sq.pop_front());
            line_lvl = line_lvl ^ s;
            r[j] = line_lvl;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %05h expected %05h", tag, got, exp);
        end
    endtask

    // One word clock: drive at the negative edge, update the model at the edge, sample at the next negative edge.
    task automatic step(input logic rst_v, input logic [19:0] d, input string tag);
        rst_n   = rst_v;
        in_word = d;
        #1;
        check("R4 hold before edge", out_word, exp_word);
        @(posedge clk);
        if (!rst_v) begin
            model_clear();
            exp_word = '0;
        end else begin
            exp_word = model_word(d);
        end
        @(negedge clk);
        check(tag, out_word, exp_word);
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        // R5: reset state
        step(1'b0, 20'hABCDE, "R5 reset");
        step(1'b0, 20'h12345, "R5 reset");
        // R7: zeros stay zero
        for (int i = 0; i < 12; i++) step(1'b1, 20'h00000, "R7 zero input");
        // R3: impulse at the first serial bit, then let it ripple
        step(1'b1, 20'h00001, "R3 bit0 impulse");
        for (int i = 0; i < 4; i++) step(1'b1, 20'h00000, "R3 impulse tail");
        step(1'b0, 20'h0, "R5 reset");
        // R3: impulse at the last serial bit (luma MSB)
        step(1'b1, 20'h80000, "R3 bit19 impulse");
        for (int i = 0; i < 4; i++) step(1'b1, 20'h00000, "R3 impulse tail");
        step(1'b1, 20'h00200, "R3 chroma msb");
        step(1'b1, 20'h00400, "R3 luma lsb");
        // R2: all-ones words exercise line toggling
        for (int i = 0; i < 10; i++) step(1'b1, 20'hFFFFF, "R2 all ones");
        // R6: repeated identical word depends on carried state
        for (int i = 0; i < 10; i++) step(1'b1, 20'h5A3C6, "R6 repeated word");
        // R1: long random stream with occasional resets (R5)
        for (int i = 0; i < 3000; i++) begin
            if (i % 700 == 350) step(1'b0, 20'($urandom), "R5 mid-run reset");
            else step(1'b1, 20'($urandom), "R1 random stream");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule